// File: doc/BRIEF.md
# Byte Rotate and Shift Unit with Condition Flags

This block takes one data byte, the current carry flag and a three-bit operation code, and moves the byte one bit position to the left or to the right. Seven operations are available. The circular rotates wrap the bit that leaves the byte back into the position it vacated. The rotates through carry wrap the incoming carry into that position. The left shift and the logical right shift fill the vacated bit with zero. The arithmetic right shift keeps the sign bit where it is. Every operation also produces a full set of condition flags from its result: sign, zero, half-carry, parity, subtract and carry.

A valid strobe starts an operation. On the next rising clock edge the result byte and the flags are captured in registers, and a one-cycle done pulse marks the new values. When no operation is requested, or when the one reserved code is applied, the registers keep their previous contents. A synchronous reset clears everything. The surrounding datapath supplies the operand and writes the result back. Decoding the wider instruction is done outside this block.

Top module: `rotshift_unit`

## Requirements
- R1: Code 000 rotates left circularly: result = {operand[6:0], operand[7]}. Code 001 rotates right circularly: result = {operand[0], operand[7:1]}.
- R2: Code 010 rotates left through carry: result = {operand[6:0], carry_in}. Code 011 rotates right through carry: result = {carry_in, operand[7:1]}.
- R3: Code 100 shifts left with a zero fill, whatever carry_in is. For every left-moving code (000, 010, 100), the new carry flag is the old operand bit 7.
- R4: Code 101 shifts right arithmetically: result = {operand[7], operand[7:1]}.
- R5: Code 111 shifts right with a zero fill, whatever carry_in is. For every right-moving code (001, 011, 101, 111), the new carry flag is the old operand bit 0.
- R6: For every update, flag_s equals result bit 7 and flag_z is 1 exactly when the result is zero. flag_h and flag_n are always 0.
- R7: For every update, flag_pv is 1 when the result has an even number of ones and 0 when the number is odd.
- R8: An update happens on the first rising edge where in_valid is 1. out_valid is 1 for exactly that cycle. Back-to-back strobes give back-to-back updates. Without a strobe, result and flags hold their values and out_valid is 0.
- R9: Code 110 is reserved. A strobe that carries it changes neither the result nor any flag, and out_valid stays 0.
- R10: When rst is 1 at a rising edge, the result, all six flags and out_valid become 0. This includes the case where in_valid is also 1 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation request strobe |
| op_sel | input | 3 | Operation code (see R1 to R5, R9) |
| operand | input | WIDTH (8) | Byte to rotate or shift |
| carry_in | input | 1 | Current carry flag |
| result | output | WIDTH (8) | Registered result byte |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_h | output | 1 | Half-carry flag (always cleared on update) |
| flag_pv | output | 1 | Parity flag, 1 for even parity |
| flag_n | output | 1 | Subtract flag (always cleared on update) |
| flag_c | output | 1 | Carry flag |
| out_valid | output | 1 | One-cycle pulse marking an update |

## Verification
The synchronous reset and an operation strobe can land on the same clock edge. To provoke this, the bench raises rst and in_valid together, with an operand that would give a non-zero result. It then checks that the result and all flags read zero and that out_valid stays low, so reset takes priority. A second overlap is a reserved-code strobe that directly follows a valid update. The bench judges it by checking that the earlier result and carry survive unchanged.

// File: rtl/rotshift_pkg.sv
package rotshift_pkg;

    typedef enum logic [2:0] {
        OP_ROL_CIRC  = 3'b000,
        OP_ROR_CIRC  = 3'b001,
        OP_ROL_CARRY = 3'b010,
        OP_ROR_CARRY = 3'b011,
        OP_SHL_ZERO  = 3'b100,
        OP_SHR_SIGN  = 3'b101,
        OP_RESERVED  = 3'b110,
        OP_SHR_ZERO  = 3'b111
    } rs_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic h;
        logic pv;
        logic n;
        logic c;
    } rs_flags_t;

endpackage

// File: rtl/rs_bit_mover.sv
module rs_bit_mover
    import rotshift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [2:0]       op_sel,
    input  logic [WIDTH-1:0] operand,
    input  logic             carry_in,
    output logic [WIDTH-1:0] moved,
    output logic             carry_out,
    output logic             legal
);
    localparam int MSB = WIDTH - 1;

    rs_op_e     op;
    logic       move_right;
    logic       fill_low;
    logic       fill_high;
    logic [WIDTH-1:0] left_val;
    logic [WIDTH-1:0] right_val;

    assign op         = rs_op_e'(op_sel);
    assign move_right = op_sel[0];

    // Bit entering at the low end for left-moving codes
    always_comb begin
        case (op)
            OP_ROL_CIRC:  fill_low = operand[MSB];
            OP_ROL_CARRY: fill_low = carry_in;
            default:      fill_low = 1'b0;
        endcase
    end

    // Bit entering at the high end for right-moving codes
    always_comb begin
        case (op)
            OP_ROR_CIRC:  fill_high = operand[0];
            OP_ROR_CARRY: fill_high = carry_in;
            OP_SHR_SIGN:  fill_high = operand[MSB];
            default:      fill_high = 1'b0;
        endcase
    end

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_lane
            if (i == 0) begin : g_low
                assign left_val[i] = fill_low;
            end else begin : g_low_n
                assign left_val[i] = operand[i-1];
            end
            if (i == MSB) begin : g_high
                assign right_val[i] = fill_high;
            end else begin : g_high_n
                assign right_val[i] = operand[i+1];
            end
        end
    endgenerate

    assign moved     = move_right ? right_val : left_val;
    assign carry_out = move_right ? operand[0] : operand[MSB];
    assign legal     = (op != OP_RESERVED);

endmodule

// File: rtl/rs_flag_gen.sv
module rs_flag_gen
    import rotshift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] value,
    input  logic             carry_bit,
    output rs_flags_t        flags
);
    // Parity chain seeded with 1 so an even count of ones ends at 1
    logic [WIDTH:0] par_chain;
    logic [WIDTH:0] any_chain;

    assign par_chain[0] = 1'b1;
    assign any_chain[0] = 1'b0;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_chain
            assign par_chain[i+1] = par_chain[i] ^ value[i];
            assign any_chain[i+1] = any_chain[i] | value[i];
        end
    endgenerate

    always_comb begin
        flags    = '0;
        flags.s  = value[WIDTH-1];
        flags.z  = ~any_chain[WIDTH];
        flags.h  = 1'b0;
        flags.pv = par_chain[WIDTH];
        flags.n  = 1'b0;
        flags.c  = carry_bit;
    end

endmodule

// File: rtl/rotshift_unit.sv
module rotshift_unit
    import rotshift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       op_sel,
    input  logic [WIDTH-1:0] operand,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             flag_s,
    output logic             flag_z,
    output logic             flag_h,
    output logic             flag_pv,
    output logic             flag_n,
    output logic             flag_c,
    output logic             out_valid
);
    typedef struct packed {
        logic [WIDTH-1:0] result;
        rs_flags_t        flags;
        logic             valid;
    } rs_state_t;

    rs_state_t        state_d;
    rs_state_t        state_q;
    logic [WIDTH-1:0] moved;
    logic             carry_out;
    logic             legal;
    rs_flags_t        next_flags;

    rs_bit_mover #(.WIDTH(WIDTH)) u_mover (
        .op_sel    (op_sel),
        .operand   (operand),
        .carry_in  (carry_in),
        .moved     (moved),
        .carry_out (carry_out),
        .legal     (legal)
    );

    rs_flag_gen #(.WIDTH(WIDTH)) u_flags (
        .value     (moved),
        .carry_bit (carry_out),
        .flags     (next_flags)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = 1'b0;
        if (in_valid && legal) begin
            state_d.result = moved;
            state_d.flags  = next_flags;
            state_d.valid  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result    = state_q.result;
    assign flag_s    = state_q.flags.s;
    assign flag_z    = state_q.flags.z;
    assign flag_h    = state_q.flags.h;
    assign flag_pv   = state_q.flags.pv;
    assign flag_n    = state_q.flags.n;
    assign flag_c    = state_q.flags.c;
    assign out_valid = state_q.valid;

endmodule

// File: rtl/rotshift_checker.sv
module rotshift_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [2:0]       op_sel,
    input logic [WIDTH-1:0] operand,
    input logic             carry_in,
    input logic [WIDTH-1:0] result,
    input logic             flag_s,
    input logic             flag_z,
    input logic             flag_h,
    input logic             flag_pv,
    input logic             flag_n,
    input logic             flag_c,
    input logic             out_valid
);
    localparam int MSB = WIDTH - 1;

    AST_CIRC_LEFT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'b000) |=> (result[0] == $past(operand[MSB]))); // R1

    AST_THRU_RIGHT_FILL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'b011) |=> (result[MSB] == $past(carry_in))); // R2

    AST_LEFT_CARRY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_sel[0] && op_sel != 3'b110) |=> (flag_c == $past(operand[MSB]))); // R3

    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'b101) |=> (result[MSB] == $past(operand[MSB]))); // R4

    AST_RIGHT_CARRY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel[0]) |=> (flag_c == $past(operand[0]))); // R5

    AST_SZHN_MATCH: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flag_s == result[MSB] && flag_z == (result == '0) && !flag_h && !flag_n)); // R6

    AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flag_pv == ~^result)); // R7

    AST_UPDATE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel != 3'b110) |=> out_valid); // R8

    AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'b110) |=> (!out_valid && $stable(result) && $stable(flag_c))); // R9

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && result == '0 && !flag_c && !flag_z)); // R10

endmodule

bind rotshift_unit rotshift_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .operand   (operand),
    .carry_in  (carry_in),
    .result    (result),
    .flag_s    (flag_s),
    .flag_z    (flag_z),
    .flag_h    (flag_h),
    .flag_pv   (flag_pv),
    .flag_n    (flag_n),
    .flag_c    (flag_c),
    .out_valid (out_valid)
);

// File: tb/tb_rotshift_unit.sv
`timescale 1ns/1ps
module tb_rotshift_unit;
    localparam int WIDTH = 8;
    localparam int NVEC  = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [2:0]       op_sel = 3'b000;
    logic [WIDTH-1:0] operand = '0;
    logic             carry_in = 1'b0;
    logic [WIDTH-1:0] result;
    logic flag_s, flag_z, flag_h, flag_pv, flag_n, flag_c, out_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    rotshift_unit #(.WIDTH(WIDTH)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .operand(operand), .carry_in(carry_in), .result(result),
        .flag_s(flag_s), .flag_z(flag_z), .flag_h(flag_h), .flag_pv(flag_pv),
        .flag_n(flag_n), .flag_c(flag_c), .out_valid(out_valid)
    );

    // {op, carry_in, operand, expected result, expected carry}
    localparam logic [20:0] VECS [NVEC] = '{
        {3'b000, 1'b0, 8'h81, 8'h03, 1'b1},
        {3'b000, 1'b1, 8'h40, 8'h80, 1'b0},
        {3'b001, 1'b0, 8'h01, 8'h80, 1'b1},
        {3'b001, 1'b1, 8'h82, 8'h41, 1'b0},
        {3'b010, 1'b1, 8'h80, 8'h01, 1'b1},
        {3'b010, 1'b0, 8'h55, 8'hAA, 1'b0},
        {3'b011, 1'b1, 8'h01, 8'h80, 1'b1},
        {3'b011, 1'b0, 8'hAA, 8'h55, 1'b0},
        {3'b100, 1'b1, 8'hC1, 8'h82, 1'b1},
        {3'b100, 1'b0, 8'h80, 8'h00, 1'b1},
        {3'b101, 1'b0, 8'h81, 8'hC0, 1'b1},
        {3'b101, 1'b1, 8'h7E, 8'h3F, 1'b0},
        {3'b111, 1'b1, 8'h81, 8'h40, 1'b1},
        {3'b111, 1'b0, 8'h01, 8'h00, 1'b1},
        {3'b111, 1'b0, 8'h00, 8'h00, 1'b0},
        {3'b000, 1'b0, 8'hFF, 8'hFF, 1'b1}
    };

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'b000, 3'b001: return "R1";
            3'b010, 3'b011: return "R2";
            3'b100:         return "R3";
            3'b101:         return "R4";
            default:        return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Flags expected from a result byte and carry, derived from R6 and R7
    task automatic check_flags(input string tag, input logic [7:0] r, input logic c);
        int ones = 0;
        for (int b = 0; b < 8; b++) ones += r[b];
        check(tag, "result", result, r);
        check(tag, "carry", flag_c, c);
        check("R6", "sign", flag_s, r[7]);
        check("R6", "zero", flag_z, (r == 8'h00));
        check("R6", "half", flag_h, 1'b0);
        check("R6", "subtract", flag_n, 1'b0);
        check("R7", "parity", flag_pv, (ones % 2 == 0));
    endtask

    task automatic apply(input logic [2:0] op, input logic cin, input logic [7:0] val);
        in_valid = 1'b1;
        op_sel   = op;
        carry_in = cin;
        operand  = val;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "reset result", result, 8'h00);
        check("R10", "reset flags", {flag_s, flag_z, flag_h, flag_pv, flag_n, flag_c}, 6'b0);
        check("R10", "reset out_valid", out_valid, 1'b0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            logic [2:0] op;
            logic       cin;
            logic [7:0] opnd;
            logic [7:0] er;
            logic       ec;
            {op, cin, opnd, er, ec} = VECS[i];
            apply(op, cin, opnd);
            check("R8", "out_valid pulse", out_valid, 1'b1);
            check_flags(req_of(op), er, ec);
        end

        // R8: hold without a strobe, pulse drops
        @(negedge clk);
        check("R8", "out_valid low when idle", out_valid, 1'b0);
        check("R8", "result held", result, 8'hFF);
        check("R8", "carry held", flag_c, 1'b1);

        // R8: back-to-back strobes
        in_valid = 1'b1; op_sel = 3'b111; carry_in = 1'b0; operand = 8'h80;
        @(negedge clk);
        check("R8", "first back-to-back", result, 8'h40);
        op_sel = 3'b000; operand = 8'h01;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8", "second back-to-back", result, 8'h02);
        check("R8", "valid stays high", out_valid, 1'b1);

        // R9: reserved code after a known update
        apply(3'b001, 1'b0, 8'h03);
        check_flags("R1", 8'h81, 1'b1);
        apply(3'b110, 1'b0, 8'hFE);
        check("R9", "reserved out_valid", out_valid, 1'b0);
        check("R9", "reserved result", result, 8'h81);
        check("R9", "reserved flags", {flag_s, flag_z, flag_h, flag_pv, flag_n, flag_c}, 6'b100101);

        // R3 and R5: zero fill ignores carry_in
        apply(3'b100, 1'b1, 8'h00);
        check("R3", "left fill ignores carry", result, 8'h00);
        apply(3'b111, 1'b1, 8'h00);
        check("R5", "right fill ignores carry", result, 8'h00);

        // R10: reset together with a strobe
        apply(3'b000, 1'b0, 8'h40);
        check("R1", "preload", result, 8'h80);
        rst = 1'b1;
        in_valid = 1'b1; op_sel = 3'b000; operand = 8'h40;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        check("R10", "reset wins result", result, 8'h00);
        check("R10", "reset wins out_valid", out_valid, 1'b0);
        check("R10", "reset wins flags", {flag_s, flag_z, flag_h, flag_pv, flag_n, flag_c}, 6'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule